// File: doc/BRIEF.md
# Gated Product Accumulator

This block sums a stream of signed products, one per clock, into a wide running total. A single accumulate-control bit, registered together with the product, marks where each run of terms begins and ends. While the registered control is high, each new product is added to the total and the visible result stays frozen. When the registered control is low, the total restarts from the current product. In that same cycle the result register takes the total as it stood before the restart. The result therefore shows the full sum of the previous run, once per run boundary.

A typical use is a multi-tap filter. The datapath feeds one product per cycle and drives the control low on the first term of every new output sample. Finished sums then leave the block at a steady rate. Products are sign-extended into the accumulator, and its guard bits let 256 full-scale terms be summed without loss.

Top module: `gacc_top`

## Requirements
- R1: A synchronous active-low reset clears the registered control, the registered product, the running total and `result_o` to zero. `result_o` reads 0 on the first falling edge after a reset edge.
- R2: When the registered control is 1, the running total becomes the previous total plus the sign-extended registered product.
- R3: When the registered control is 1, `result_o` keeps its previous value.
- R4: When the registered control is 0, the running total is reloaded with the sign-extended registered product alone.
- R5: When the registered control is 0, `result_o` loads the running total from before that edge. This is the complete sum of the previous run.
- R6: `acc_en_i` and `prod_i` are captured together on the same rising edge. The resulting change shows on `result_o` after the following rising edge, two edges after the inputs were presented.
- R7: Products are two's-complement. A run of 256 products of -2^23 (24-bit value 0x800000) yields exactly -2^31 (32-bit value 0x80000000) with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prod_i | input | 24 | Signed product term |
| acc_en_i | input | 1 | 1 = add the term to the current run, 0 = start a new run with the term |
| result_o | output | 32 | Signed sum of the last completed run |

## Verification
Some properties hold on every cycle, and the assertions check them. These are:
- the one-edge capture of the control;
- the add and restart updates of the running total;
- the freeze of the result while accumulating;
- the load of the pre-restart total;
- the zeroing by reset.

Other properties only show up across whole runs, and only the bench's scenarios can show them. These include the run-boundary semantics seen at the port, the two-edge latency, and that runs of length one, negative terms and the 256-term full-scale run produce the right completed sums.

// File: rtl/gacc_pkg.sv
// Package: shared widths for the gated accumulator.
// Assumes ACC_W > PROD_W so the accumulator carries guard bits.
package gacc_pkg;
    localparam int PROD_W = 24;
    localparam int ACC_W  = 32;
endpackage

// File: rtl/gacc_in_stage.sv
// Module: input stage. Registers the product term and the accumulate
// control on the same edge so that both reach the core aligned.
// Assumes a synchronous active-low reset.
module gacc_in_stage #(
    parameter int PROD_W = gacc_pkg::PROD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [PROD_W-1:0] prod_i,
    input  logic                     acc_en_i,
    output logic signed [PROD_W-1:0] prod_q,
    output logic                     acc_q
);
    // Capture the term and its control together; reset clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            acc_q  <= 1'b0;
        end else begin
            prod_q <= prod_i;
            acc_q  <= acc_en_i;
        end
    end
endmodule

// File: rtl/gacc_core.sv
// Module: accumulator core. Adds the sign-extended term to the running
// total while acc_q is high, and restarts the total from the term when
// it is low. Assumes ACC_W >= PROD_W.
module gacc_core #(
    parameter int PROD_W = gacc_pkg::PROD_W,
    parameter int ACC_W  = gacc_pkg::ACC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [PROD_W-1:0] prod_q,
    input  logic                     acc_q,
    output logic signed [ACC_W-1:0]  sum_q
);
    localparam int GUARD = ACC_W - PROD_W;

    logic signed [ACC_W-1:0] term_ext;
    logic signed [ACC_W-1:0] sum_d;

    // Sign-extend the term into the accumulator width.
    always_comb term_ext = {{GUARD{prod_q[PROD_W-1]}}, prod_q};

    // Pick between continuing the run and restarting it.
    always_comb sum_d = acc_q ? (sum_q + term_ext) : term_ext;

    // Hold the running total; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end
endmodule

// File: rtl/gacc_out_reg.sv
// Module: result register. Loads the running total whenever the
// registered control is low (run boundary) and holds otherwise.
// Assumes sum_q is the total before the current edge's update.
module gacc_out_reg #(
    parameter int ACC_W = gacc_pkg::ACC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_q,
    input  logic signed [ACC_W-1:0] sum_q,
    output logic signed [ACC_W-1:0] result_q
);
    // Load on a run boundary, freeze during accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n)      result_q <= '0;
        else if (!acc_q) result_q <= sum_q;
    end
endmodule

// File: rtl/gacc_top.sv
// Module: gated product accumulator top. Input stage -> core -> result
// register. Results of each run appear at its boundary, two edges after
// the boundary term is presented. Synchronous active-low reset.
module gacc_top #(
    parameter int PROD_W = gacc_pkg::PROD_W,
    parameter int ACC_W  = gacc_pkg::ACC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [PROD_W-1:0] prod_i,
    input  logic                     acc_en_i,
    output logic signed [ACC_W-1:0]  result_o
);
    localparam int GUARD = ACC_W - PROD_W;

    logic signed [PROD_W-1:0] prod_q;
    logic                     acc_q;
    logic signed [ACC_W-1:0]  sum_q;

    gacc_in_stage #(.PROD_W(PROD_W)) u_in (
        .clk(clk), .rst_n(rst_n), .prod_i(prod_i), .acc_en_i(acc_en_i),
        .prod_q(prod_q), .acc_q(acc_q)
    );

    gacc_core #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_core (
        .clk(clk), .rst_n(rst_n), .prod_q(prod_q), .acc_q(acc_q),
        .sum_q(sum_q)
    );

    gacc_out_reg #(.ACC_W(ACC_W)) u_out (
        .clk(clk), .rst_n(rst_n), .acc_q(acc_q), .sum_q(sum_q),
        .result_q(result_o)
    );

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && sum_q == '0 && !acc_q));

    assert_add_term_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q |=> sum_q == $past(sum_q) + {{GUARD{$past(prod_q[PROD_W-1])}}, $past(prod_q)});

    assert_hold_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q |=> $stable(result_o));

    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_q |=> sum_q == {{GUARD{$past(prod_q[PROD_W-1])}}, $past(prod_q)});

    assert_load_prev_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_q |=> result_o == $past(sum_q));

    assert_ctrl_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> acc_q == $past(acc_en_i));
endmodule

// File: tb/gacc_top_test.sv
`timescale 1ns/1ps
module gacc_top_test;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [23:0] prod_i = '0;
    logic               acc_en_i = 1'b0;
    logic signed [31:0] result_o;

    typedef struct {
        int                 due;
        logic signed [31:0] exp;
        string              tag;
    } item_t;

    item_t              sb[$];
    int                 cyc = 0;
    int                 n_chk = 0;
    int                 n_bad = 0;
    logic signed [31:0] run_sum = '0;
    logic signed [31:0] last_res = '0;

    gacc_top uut (.clk(clk), .rst_n(rst_n), .prod_i(prod_i),
                  .acc_en_i(acc_en_i), .result_o(result_o));

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic signed [31:0] act, input logic signed [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: result_o=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: present one term and push the result expected two edges later (R6).
    task automatic apply(input logic signed [23:0] p, input logic c);
        item_t it;
        @(negedge clk);
        prod_i = p;
        acc_en_i = c;
        it.due = cyc + 2;
        if (c) begin
            run_sum = run_sum + {{8{p[23]}}, p};   // R2 add, R7 sign extension
            it.exp = last_res;                     // R3 hold
            it.tag = "R3 hold while accumulating";
        end else begin
            it.exp = run_sum;                      // R5 previous run's total
            last_res = run_sum;
            run_sum = {{8{p[23]}}, p};             // R4 restart
            it.tag = "R5/R4/R6 load at run boundary";
        end
        sb.push_back(it);
    endtask

    // Monitor: compare due items away from the rising edge.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            check(result_o, it.exp, it.tag);
        end
    end

    task automatic drain();
        apply(24'sd0, 1'b1);
        while (sb.size() > 0) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        prod_i = '0;
        acc_en_i = 1'b0;
        @(negedge clk);
        check(result_o, 32'sd0, "R1 reset clears result");
        @(negedge clk);
        rst_n = 1'b1;
        run_sum = '0;
        last_res = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(result_o, 32'sd0, "R1 reset state");
        rst_n = 1'b1;
        // R2/R5: a 4-term positive run, closed by a new run.
        apply(24'sd10, 1'b0);
        apply(24'sd20, 1'b1);
        apply(24'sd30, 1'b1);
        apply(24'sd40, 1'b1);
        apply(24'sd5, 1'b0);
        // R7: negative terms in a run.
        apply(-24'sd100, 1'b1);
        apply(-24'sd7, 1'b1);
        apply(24'sd1, 1'b0);
        // R4: runs of length one, back to back.
        apply(24'sd111, 1'b0);
        apply(-24'sd222, 1'b0);
        apply(24'sd333, 1'b0);
        // R7: 256 full-scale negative terms give exactly -2^31.
        apply(-24'sd8388608, 1'b0);
        for (int i = 0; i < 255; i++) apply(-24'sd8388608, 1'b1);
        apply(24'sd0, 1'b0);
        drain();
        check(result_o, -32'sd2147483648, "R7 full-scale run");
        // R1: reset in the middle of a run discards it.
        apply(24'sd50, 1'b0);
        apply(24'sd60, 1'b1);
        drain();
        do_reset();
        apply(24'sd9, 1'b0);
        apply(24'sd9, 1'b1);
        apply(24'sd3, 1'b0);
        drain();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule